// File: doc/BRIEF.md
# Iterative IDEA Block Encryption Core

This core encrypts one 64-bit block under a 128-bit key with the IDEA cipher. It keeps a single combinational round unit and runs it once per clock over a four-word state register. The round unit mixes three operations: bitwise XOR, addition modulo 2^16 and multiplication modulo 2^16+1. There are no lookup tables. Eight full rounds run first, then a half-round output stage. All 52 subkeys come from the latched key. Key expansion is pure wiring, with a small selector that picks six subkeys for each step.

The user drives plaintext and key and pulses start while the core is idle. The core raises busy for the whole computation. It then pulses done for one cycle and presents the ciphertext on a registered output. The ciphertext stays unchanged until the next accepted start. Only one block is in flight at a time. A start that arrives while busy is dropped.

Top module: `idea_iter_core`

## Requirements
- R1: While reset is high and after it is released, with no start applied, busy_o, done_o and cipher_o are all zero.
- R2: A start_i pulse sampled while busy_o is low captures plain_i and key_i, and busy_o is high from the following cycle.
- R3: done_o goes high exactly NUM_ROUNDS+1 clock edges after the edge that accepted start (9 with the default of 8 rounds) and stays high for exactly one cycle.
- R4: cipher_o equals the IDEA encryption of the captured block. The block splits into four 16-bit words, with X1 at bits 63:48. Each round r uses subkeys 6r+1..6r+6 and computes t1=X1*Z1, t2=X2+Z2, t3=X3+Z3, t4=X4*Z4, a=(t1^t3)*Z5, b=((t2^t4)+a)*Z6, c=a+b. The round outputs, in order, are t1^b, t3^b, t2^c, t4^c. The output stage gives Y1=X1*Z49, Y2=X3+Z50, Y3=X2+Z51, Y4=X4*Z52.
- R5: Subkeys are the 16-bit words of the key taken from the most significant end, eight at a time. After each eight, the key is rotated left by 25 bits. This continues until 52 words exist.
- R6: In the modulo 2^16+1 multiplication, a word value of 0 stands for 2^16, both as an operand and as a result. This holds for zero data words, zero subkeys and products that land on 2^16.
- R7: A start_i pulse while busy_o is high is ignored. The running block's ciphertext and done timing are unchanged.
- R8: While busy_o is low, cipher_o does not change, whatever plain_i and key_i do, until a new start is accepted.
- R9: busy_o and done_o are never high in the same cycle.
- R10: With key 0001 0002 0003 0004 0005 0006 0007 0008 and plaintext 0000 0001 0002 0003 (hex words), the ciphertext is 11FB ED2B 0198 6DE5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| plain_i | input | 64 | Plaintext block, X1 in bits 63:48 |
| key_i | input | 128 | Cipher key, first subkey in bits 127:112 |
| busy_o | output | 1 | High while a block is being encrypted |
| done_o | output | 1 | One-cycle pulse when cipher_o is updated |
| cipher_o | output | 64 | Ciphertext, held until the next accepted start |

## Verification
Some behaviours are checked by assertions on every cycle. These are the mutual exclusion of busy and done, the single-cycle done pulse, the exact start-to-done latency (counted in the checker), acceptance of an idle start, and an unchanging ciphertext while idle. The numerical correctness of the rounds, the key schedule and the zero-as-2^16 convention is shown only by the bench. The bench compares against an independent arithmetic model over directed zero and all-ones patterns, a known vector and a long pseudo-random sweep. Dropped starts during a run and ciphertext hold under changing inputs are also bench scenarios.

// File: rtl/idea_pkg.sv
package idea_pkg;

  // Word width is fixed by the cipher itself.
  localparam int WORD_W  = 16;
  localparam int BLOCK_W = 4 * WORD_W;
  localparam int KEY_W   = 8 * WORD_W;
  localparam int SUBK_PER_ROUND = 6;

  typedef logic [WORD_W-1:0] word_t;

  // Multiplication modulo 2^16+1 with 0 standing for 2^16.
  // Low/high decomposition: for nonzero a,b, p = hi*2^16 + lo,
  // and 2^16 == -1, so result = lo - hi (+1 on borrow).
  function automatic word_t mul_mod(input word_t a, input word_t b);
    logic [2*WORD_W-1:0] prod;
    word_t lo, hi;
    word_t res;
    if (a == '0) begin
      res = word_t'(1) - b;
    end else if (b == '0) begin
      res = word_t'(1) - a;
    end else begin
      prod = a * b;
      lo   = prod[WORD_W-1:0];
      hi   = prod[2*WORD_W-1:WORD_W];
      res  = lo - hi + ((lo < hi) ? word_t'(1) : word_t'(0));
    end
    return res;
  endfunction

endpackage

// File: rtl/idea_key_sched.sv
module idea_key_sched
  import idea_pkg::*;
#(
  parameter int NUM_ROUNDS = 8,
  parameter int KEY_ROT    = 25,
  parameter int RND_W      = 4
) (
  input  logic [KEY_W-1:0]                   key_i,
  input  logic [RND_W-1:0]                   rnd_i,
  output logic [SUBK_PER_ROUND*WORD_W-1:0]   subk_o
);

  localparam int NSUB  = SUBK_PER_ROUND * NUM_ROUNDS + 4;
  localparam int NGRP  = (NSUB + 7) / 8;
  localparam int NPAD  = NSUB + 2;

  logic [KEY_W-1:0] grp   [NGRP];
  word_t            words [NPAD];

  // Each group of eight subkeys is a fixed rotation of the key: wiring only.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int SH = (KEY_ROT * g) % KEY_W;
    if (SH == 0) begin : g_norot
      assign grp[g] = key_i;
    end else begin : g_rot
      assign grp[g] = {key_i[KEY_W-1-SH:0], key_i[KEY_W-1:KEY_W-SH]};
    end
  end

  for (genvar k = 0; k < NPAD; k++) begin : g_word
    if (k < NSUB) begin : g_used
      assign words[k] = grp[k/8][KEY_W-1-WORD_W*(k%8) -: WORD_W];
    end else begin : g_pad
      assign words[k] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < SUBK_PER_ROUND; i++) begin
      subk_o[(SUBK_PER_ROUND-1-i)*WORD_W +: WORD_W] =
        words[SUBK_PER_ROUND * int'(rnd_i) + i];
    end
  end

endmodule

// File: rtl/idea_round_unit.sv
module idea_round_unit
  import idea_pkg::*;
(
  input  logic [BLOCK_W-1:0]                 state_i,
  input  logic [SUBK_PER_ROUND*WORD_W-1:0]   subk_i,
  output logic [BLOCK_W-1:0]                 round_o,
  output logic [BLOCK_W-1:0]                 final_o
);

  word_t x1, x2, x3, x4;
  word_t z1, z2, z3, z4, z5, z6;
  word_t t1, t2, t3, t4;
  word_t a, b, c;

  always_comb begin
    {x1, x2, x3, x4}         = state_i;
    {z1, z2, z3, z4, z5, z6} = subk_i;

    t1 = mul_mod(x1, z1);
    t2 = x2 + z2;
    t3 = x3 + z3;
    t4 = mul_mod(x4, z4);

    a = mul_mod(t1 ^ t3, z5);
    b = mul_mod((t2 ^ t4) + a, z6);
    c = a + b;

    // Middle words come out exchanged.
    round_o = {t1 ^ b, t3 ^ b, t2 ^ c, t4 ^ c};

    // Output stage: undo the exchange of the last round.
    final_o = {t1, x3 + z2, x2 + z3, t4};
  end

endmodule

// File: rtl/idea_seq_ctrl.sv
module idea_seq_ctrl #(
  parameter int NUM_ROUNDS = 8,
  parameter int RND_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS);

  logic             busy_q, done_q;
  logic [RND_W-1:0] rnd_q;

  assign load_o = start_i && !busy_q;
  assign fin_o  = busy_q && (rnd_q == LAST);
  assign step_o = busy_q && (rnd_q != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        rnd_q  <= '0;
      end else if (fin_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rnd_q  <= '0;
      end else if (step_o) begin
        rnd_q  <= rnd_q + 1'b1;
      end
    end
  end

  assign rnd_o  = rnd_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/idea_iter_core.sv
module idea_iter_core
  import idea_pkg::*;
#(
  parameter int NUM_ROUNDS = 8,
  parameter int KEY_ROT    = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [63:0]  plain_i,
  input  logic [127:0] key_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [63:0]  cipher_o
);

  localparam int RND_W = $clog2(NUM_ROUNDS + 1);

  logic                               load, step, fin;
  logic [RND_W-1:0]                   rnd;
  logic [KEY_W-1:0]                   key_q;
  logic [BLOCK_W-1:0]                 st_q, ct_q;
  logic [SUBK_PER_ROUND*WORD_W-1:0]   subk;
  logic [BLOCK_W-1:0]                 round_nxt, final_nxt;

  idea_seq_ctrl #(
    .NUM_ROUNDS (NUM_ROUNDS),
    .RND_W      (RND_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .rnd_o   (rnd),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  idea_key_sched #(
    .NUM_ROUNDS (NUM_ROUNDS),
    .KEY_ROT    (KEY_ROT),
    .RND_W      (RND_W)
  ) ksched_i (
    .key_i  (key_q),
    .rnd_i  (rnd),
    .subk_o (subk)
  );

  idea_round_unit round_i (
    .state_i (st_q),
    .subk_i  (subk),
    .round_o (round_nxt),
    .final_o (final_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      st_q  <= '0;
      ct_q  <= '0;
    end else begin
      if (load) begin
        key_q <= key_i;
        st_q  <= plain_i;
      end else if (step) begin
        st_q  <= round_nxt;
      end
      if (fin) begin
        ct_q  <= final_nxt;
      end
    end
  end

  assign cipher_o = ct_q;

endmodule

// File: rtl/idea_iter_core_chk.sv
module idea_iter_core_chk #(
  parameter int NUM_ROUNDS = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [63:0] cipher_o
);

  logic [15:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)                   lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)           lat_q <= lat_q + 1'b1;
  end

  p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == 16'(NUM_ROUNDS + 1)));

  p_done_from_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(cipher_o));

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

endmodule

bind idea_iter_core idea_iter_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cipher_o (cipher_o)
);

// File: tb/idea_iter_core_tb_top.sv
module idea_iter_core_tb_top;

  localparam int NR = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [63:0]  plain_i;
  logic [127:0] key_i;
  logic         busy_o, done_o;
  logic [63:0]  cipher_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  idea_iter_core #(.NUM_ROUNDS(NR), .KEY_ROT(25)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .plain_i(plain_i),
    .key_i(key_i), .busy_o(busy_o), .done_o(done_o), .cipher_o(cipher_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference arithmetic, written independently of the RTL.
  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    longint aa, bb, r;
    aa = (a == 0) ? 65536 : longint'(a);
    bb = (b == 0) ? 65536 : longint'(b);
    r  = (aa * bb) % 65537;
    return (r == 65536) ? 16'h0000 : r[15:0];
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [127:0] key);
    logic [15:0]  z [52];
    logic [127:0] k;
    logic [15:0]  x1, x2, x3, x4, t1, t2, t3, t4, a, b, c;
    k = key;
    for (int i = 0; i < 52; i++) begin
      z[i] = k[127 - 16*(i % 8) -: 16];
      if (i % 8 == 7) k = {k[102:0], k[127:103]};
    end
    {x1, x2, x3, x4} = pt;
    for (int r = 0; r < NR; r++) begin
      t1 = ref_mul(x1, z[6*r]);
      t2 = x2 + z[6*r+1];
      t3 = x3 + z[6*r+2];
      t4 = ref_mul(x4, z[6*r+3]);
      a  = ref_mul(t1 ^ t3, z[6*r+4]);
      b  = ref_mul((t2 ^ t4) + a, z[6*r+5]);
      c  = a + b;
      x1 = t1 ^ b; x2 = t3 ^ b; x3 = t2 ^ c; x4 = t4 ^ c;
    end
    return {ref_mul(x1, z[48]), x3 + z[49], x2 + z[50], ref_mul(x4, z[51])};
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 7);
    v = v ^ (v << 17);
    return v;
  endfunction

  // Runs one block; optional extra start pulse mid-run with other data.
  task automatic run_block(input logic [63:0] pt, input logic [127:0] key,
                           input bit poke, input string req);
    int cyc;
    logic [63:0] exp;
    exp = ref_enc(pt, key);
    @(negedge clk);
    start_i = 1'b1; plain_i = pt; key_i = key;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2", {63'd0, busy_o}, 64'd1);
    cyc = 0;
    for (int i = 1; i <= 20; i++) begin
      if (poke && i == 3) begin
        start_i = 1'b1; plain_i = ~pt; key_i = ~key;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (done_o) begin cyc = i; break; end
    end
    start_i = 1'b0;
    chk(cyc == NR + 1, poke ? "R7" : "R3", 64'(cyc), 64'(NR + 1));
    chk(cipher_o === exp, req, cipher_o, exp);
    chk(busy_o === 1'b0, "R9", {63'd0, busy_o}, 64'd0);
    @(negedge clk);
    chk(done_o === 1'b0, "R3", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0]  held;
    logic [127:0] rk;
    rst = 1'b1; start_i = 1'b0; plain_i = '0; key_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o === 1'b0, "R1", {63'd0, busy_o}, 64'd0);
    chk(done_o === 1'b0, "R1", {63'd0, done_o}, 64'd0);
    chk(cipher_o === 64'd0, "R1", cipher_o, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && cipher_o === 64'd0, "R1",
        cipher_o, 64'd0);

    // R10: known vector, also checked against the bench model
    chk(ref_enc(64'h0000000100020003, 128'h00010002000300040005000600070008)
        === 64'h11FBED2B01986DE5, "R10", 0, 64'h11FBED2B01986DE5);
    run_block(64'h0000000100020003, 128'h00010002000300040005000600070008, 1'b0, "R10");

    // R6: zero words stand for 2^16
    run_block(64'h0, 128'h0, 1'b0, "R6");
    run_block(64'h0000FFFF00000001, 128'h0, 1'b0, "R6");
    run_block(64'h0, {8{16'h0001}}, 1'b0, "R6");
    run_block({4{16'hFFFF}}, {8{16'hFFFF}}, 1'b0, "R6");
    run_block(64'h8000000080000000, 128'h0000FFFF0000FFFF0000FFFF0000FFFF, 1'b0, "R6");

    // R5: single-bit keys exercise every rotation position
    for (int j = 0; j < 128; j += 9) begin
      run_block(64'h0123456789ABCDEF, 128'd1 << j, 1'b0, "R5");
    end

    // R4: pseudo-random sweep
    for (int j = 0; j < 60; j++) begin
      rng = next_rng(rng); rk[127:64] = rng;
      rng = next_rng(rng); rk[63:0]   = rng;
      rng = next_rng(rng);
      run_block(rng, rk, 1'b0, "R4");
    end

    // R7: start while busy is ignored
    run_block(64'hDEADBEEFCAFEF00D, 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, 1'b1, "R7");

    // R8: ciphertext holds while idle with changing inputs
    held = cipher_o;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      plain_i = {2{32'(j * 7919)}}; key_i = ~key_i;
    end
    chk(cipher_o === held, "R8", cipher_o, held);
    chk(busy_o === 1'b0, "R8", {63'd0, busy_o}, 64'd0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule